// File: doc/BRIEF.md
# Immediate-Shift Operand Unit With Carry

This block forms the second operand of a data-processing or load/store datapath from a register value and an immediate shift encoded in the instruction word. It is purely combinational. It extracts the shift amount, the shift type and the source register index from the instruction word. It applies the shift to the supplied register value and produces the shifted operand together with a shifter carry-out.

A shift amount of zero does not always mean "no shift". For the two right shifts it stands for a full-width shift by 32. For rotate it stands for a one-bit rotate through the carry flag. Only a logical left shift by zero passes the operand unchanged. The consumer reads the source index output, fetches the register and feeds its value back in. It also supplies the current carry flag and says whether flags are being updated.

Top module: `imm_shift_unit`

## Requirements
- R1: The shift amount is instruction bits 11:7, the shift type is bits 6:5 and `src_idx_o` equals bits 3:0. Type codes: 0 logical left, 1 logical right, 2 arithmetic right, 3 rotate right.
- R2: Logical left by a nonzero n gives `value_i << n`, and the raw carry is `value_i[32-n]`.
- R3: Logical left by zero gives `value_i` unchanged, and the raw carry equals `carry_i`.
- R4: Logical right by a nonzero n gives `value_i >> n` with zero fill, and the raw carry is `value_i[n-1]`.
- R5: Logical right with amount zero gives all zeros, and the raw carry is `value_i[31]`.
- R6: Arithmetic right by a nonzero n fills with `value_i[31]`, and the raw carry is `value_i[n-1]`.
- R7: Arithmetic right with amount zero sets every result bit to `value_i[31]`, and the raw carry is `value_i[31]`.
- R8: Rotate right by a nonzero n gives `(x >> n) | (x << (32-n))`, and the raw carry is result bit 31.
- R9: Rotate right with amount zero gives `{carry_i, value_i[31:1]}`, and the raw carry is `value_i[0]`.
- R10: When `flag_en_i` is high, `carry_o` is the raw carry. When it is low, `carry_o` equals `carry_i` and `operand_o` is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| insn_i | input | 32 | Instruction word holding the shift and register fields |
| value_i | input | 32 | Value of the source register |
| carry_i | input | 1 | Current carry flag |
| flag_en_i | input | 1 | High when the instruction updates flags |
| src_idx_o | output | 4 | Source register index decoded from the instruction |
| operand_o | output | 32 | Shifted operand |
| carry_o | output | 1 | Shifter carry-out |

## Verification
The checker evaluates several behaviours continuously on whatever inputs are present:
- the source index decode;
- the carry hold when flags are not updated;
- the four zero-amount reinterpretations (pass-through, all zeros, sign fill and rotate through carry).

Nonzero shift results, and the choice of carry bit for each type and amount, depend on arithmetic over the amount. Only the bench's sweep shows these. It covers every type and every amount against several operand patterns, with the carry and flag-enable inputs toggled.

// File: rtl/isu_pkg.sv
package isu_pkg;
  localparam int unsigned INSN_W   = 32;
  localparam int unsigned AMT_LSB  = 7;
  localparam int unsigned KIND_LSB = 5;
  localparam int unsigned IDX_LSB  = 0;
  localparam int unsigned IDX_W    = 4;

  typedef enum logic [1:0] {
    SHK_LSL = 2'd0,
    SHK_LSR = 2'd1,
    SHK_ASR = 2'd2,
    SHK_ROR = 2'd3
  } shift_kind_e;
endpackage

// File: rtl/isu_field_decode.sv
module isu_field_decode
  import isu_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  localparam int unsigned SHW = $clog2(XLEN)
) (
  input  logic [INSN_W-1:0] insn_i,
  output logic [SHW-1:0]    amt_o,
  output shift_kind_e       kind_o,
  output logic [IDX_W-1:0]  idx_o
);
  assign amt_o  = insn_i[AMT_LSB +: SHW];
  assign kind_o = shift_kind_e'(insn_i[KIND_LSB +: 2]);
  assign idx_o  = insn_i[IDX_LSB +: IDX_W];
endmodule

// File: rtl/isu_shift_core.sv
module isu_shift_core
  import isu_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  localparam int unsigned SHW = $clog2(XLEN)
) (
  input  logic [XLEN-1:0] x_i,
  input  logic [SHW-1:0]  amt_i,
  input  shift_kind_e     kind_i,
  input  logic            carry_i,
  output logic [XLEN-1:0] res_o,
  output logic            cout_o
);
  // Left shifts are done as a right rotate by the two's complement amount
  logic [SHW-1:0] rot_amt;
  assign rot_amt = (kind_i == SHK_LSL) ? (~amt_i + 1'b1) : amt_i;

  logic [XLEN-1:0] stage [SHW+1];
  assign stage[0] = x_i;
  for (genvar s = 0; s < SHW; s++) begin : g_rot
    localparam int unsigned D = 1 << s;
    assign stage[s+1] = rot_amt[s] ? {stage[s][D-1:0], stage[s][XLEN-1:D]} : stage[s];
  end

  logic [XLEN-1:0] rot, lsr_mask, lsl_mask;
  logic            sign, zero_amt;
  logic [SHW-1:0]  lo_idx, hi_idx;
  assign rot      = stage[SHW];
  assign lsr_mask = {XLEN{1'b1}} >> amt_i;
  assign lsl_mask = {XLEN{1'b1}} << amt_i;
  assign sign     = x_i[XLEN-1];
  assign zero_amt = (amt_i == '0);
  assign lo_idx   = amt_i - 1'b1;
  assign hi_idx   = ~amt_i + 1'b1;

  always_comb begin
    res_o  = x_i;
    cout_o = carry_i;
    unique case (kind_i)
      SHK_LSL: if (!zero_amt) begin
        res_o  = rot & lsl_mask;
        cout_o = x_i[hi_idx];
      end
      SHK_LSR: if (zero_amt) begin
        res_o  = '0;
        cout_o = sign;
      end else begin
        res_o  = rot & lsr_mask;
        cout_o = x_i[lo_idx];
      end
      SHK_ASR: if (zero_amt) begin
        res_o  = {XLEN{sign}};
        cout_o = sign;
      end else begin
        res_o  = (rot & lsr_mask) | ({XLEN{sign}} & ~lsr_mask);
        cout_o = x_i[lo_idx];
      end
      SHK_ROR: if (zero_amt) begin
        res_o  = {carry_i, x_i[XLEN-1:1]};
        cout_o = x_i[0];
      end else begin
        res_o  = rot;
        cout_o = rot[XLEN-1];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/isu_carry_sel.sv
module isu_carry_sel (
  input  logic raw_i,
  input  logic carry_i,
  input  logic en_i,
  output logic carry_o
);
  assign carry_o = en_i ? raw_i : carry_i;
endmodule

// File: rtl/imm_shift_unit.sv
module imm_shift_unit
  import isu_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [INSN_W-1:0] insn_i,
  input  logic [XLEN-1:0]   value_i,
  input  logic              carry_i,
  input  logic              flag_en_i,
  output logic [IDX_W-1:0]  src_idx_o,
  output logic [XLEN-1:0]   operand_o,
  output logic              carry_o
);
  localparam int unsigned SHW = $clog2(XLEN);

  logic [SHW-1:0] amt;
  shift_kind_e    kind;
  logic           raw_carry;

  isu_field_decode #(.XLEN(XLEN)) i_dec (
    .insn_i (insn_i),
    .amt_o  (amt),
    .kind_o (kind),
    .idx_o  (src_idx_o)
  );

  isu_shift_core #(.XLEN(XLEN)) i_core (
    .x_i     (value_i),
    .amt_i   (amt),
    .kind_i  (kind),
    .carry_i (carry_i),
    .res_o   (operand_o),
    .cout_o  (raw_carry)
  );

  isu_carry_sel i_csel (
    .raw_i   (raw_carry),
    .carry_i (carry_i),
    .en_i    (flag_en_i),
    .carry_o (carry_o)
  );
endmodule

// File: rtl/isu_checker.sv
module isu_checker
  import isu_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input logic [INSN_W-1:0] insn_i,
  input logic [XLEN-1:0]   value_i,
  input logic              carry_i,
  input logic              flag_en_i,
  input logic [IDX_W-1:0]  src_idx_o,
  input logic [XLEN-1:0]   operand_o,
  input logic              carry_o
);
  logic       zero_amt;
  logic [1:0] kind;
  assign zero_amt = (insn_i[11:7] == 5'd0);
  assign kind     = insn_i[6:5];

  always_comb begin
    assert_src_idx_R1: assert (src_idx_o == insn_i[3:0]) else $error("src idx decode");
    assert_hold_carry_R10: assert (flag_en_i || carry_o == carry_i) else $error("carry hold");
    assert_lsl_zero_R3: assert (!(zero_amt && kind == 2'd0) || (operand_o == value_i && carry_o == carry_i))
      else $error("lsl zero");
    assert_lsr_zero_R5: assert (!(zero_amt && kind == 2'd1) || operand_o == '0) else $error("lsr zero");
    assert_asr_zero_R7: assert (!(zero_amt && kind == 2'd2) || operand_o == {XLEN{value_i[XLEN-1]}})
      else $error("asr zero");
    assert_rrx_R9: assert (!(zero_amt && kind == 2'd3) ||
                           (operand_o[XLEN-1] == carry_i && operand_o[XLEN-2:0] == value_i[XLEN-1:1]))
      else $error("rrx");
  end
endmodule

bind imm_shift_unit isu_checker #(.XLEN(XLEN)) i_isu_checker (
  .insn_i    (insn_i),
  .value_i   (value_i),
  .carry_i   (carry_i),
  .flag_en_i (flag_en_i),
  .src_idx_o (src_idx_o),
  .operand_o (operand_o),
  .carry_o   (carry_o)
);

// File: tb/test_imm_shift_unit.sv
module test_imm_shift_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYCLES = 100000;

  logic        clk = 1'b0;
  logic [31:0] insn, value;
  logic        carry, flag_en;
  logic [3:0]  src_idx;
  logic [31:0] operand;
  logic        cout;
  int          n_run = 0, n_fail = 0, cycles = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  imm_shift_unit i_imm_shift_unit (
    .insn_i (insn), .value_i (value), .carry_i (carry), .flag_en_i (flag_en),
    .src_idx_o (src_idx), .operand_o (operand), .carry_o (cout)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WDOG_CYCLES && !done) begin
      n_fail++;
      $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cycles, WDOG_CYCLES);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h (type=%0d amt=%0d val=%h c=%b f=%b)",
               req, act, exp, insn[6:5], insn[11:7], value, carry, flag_en);
    end
  endtask

  task automatic apply(input logic [31:0] i, input logic [31:0] v, input logic c, input logic f);
    @(negedge clk);
    insn = i; value = v; carry = c; flag_en = f;
    #(CLK_PERIOD/4);
  endtask

  initial begin
    logic [31:0] pats [6];
    pats[0] = 32'h8000_0001; pats[1] = 32'h7fff_fffe; pats[2] = 32'hdead_beef;
    pats[3] = 32'h0123_4567; pats[4] = 32'hffff_ffff; pats[5] = 32'h0000_0000;

    // all-zero inputs: R1 idx, R3 pass-through
    apply(32'h0, 32'h0, 1'b0, 1'b0);
    check("R1", {28'h0, src_idx}, 32'h0);
    check("R3", operand, 32'h0);

    for (int t = 0; t < 4; t++) begin
      for (int a = 0; a < 32; a++) begin
        for (int p = 0; p < 6; p++) begin
          for (int cf = 0; cf < 4; cf++) begin
            logic [31:0] x, er, iw;
            logic        ci, fe, ec;
            string       rq;
            x = pats[p]; ci = cf[0]; fe = cf[1];
            iw = {20'hA5A5A, a[4:0], t[1:0], 1'b0, 4'(a + p)};
            case (t)
              0: if (a == 0) begin er = x; ec = ci; rq = "R3"; end
                 else begin er = x << a; ec = x[32-a]; rq = "R2"; end
              1: if (a == 0) begin er = 32'h0; ec = x[31]; rq = "R5"; end
                 else begin er = x >> a; ec = x[a-1]; rq = "R4"; end
              2: if (a == 0) begin er = {32{x[31]}}; ec = x[31]; rq = "R7"; end
                 else begin er = 32'($signed(x) >>> a); ec = x[a-1]; rq = "R6"; end
              default: if (a == 0) begin er = {ci, x[31:1]}; ec = x[0]; rq = "R9"; end
                 else begin er = (x >> a) | (x << (32 - a)); ec = er[31]; rq = "R8"; end
            endcase
            apply(iw, x, ci, fe);
            check(rq, operand, er);
            if (fe) check(rq, {31'h0, cout}, {31'h0, ec});
            else    check("R10", {31'h0, cout}, {31'h0, ci});
            if (cf == 0) check("R1", {28'h0, src_idx}, {28'h0, iw[3:0]});
          end
        end
      end
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule